// File: doc/BRIEF.md
# Inter-Core Mailbox Bank with Set and Clear Windows

This block holds a bank of 32-bit message words used by processor cores to signal one another. There are four cores with four mailboxes each, sixteen words in total. A sending core ORs bits into a target mailbox through one address window. The receiving core reads the word and then clears the bits it has handled through a second window that maps the same storage.

The bank drives one pending flag per mailbox. A flag is high while its word holds any set bit, and an interrupt router further down the chain consumes these flags. The register bus carries one access per cycle. A write commits on the clock edge where the write strobe is high. Read data is combinational and is valid in the cycle the read strobe is high.

Each mailbox therefore has two aliases. The clear alias returns the word on a read, and the set alias always reads as zero.

Top module: `mbox_bank`

## Requirements
- R1: While reset is low, and after it is released, every mailbox holds zero and every pending flag is low.
- R2: A write to byte offset 0x80 + 4*k, for k from 0 to 15, ORs the write data into mailbox k at that clock edge. Bits that were already set stay set.
- R3: A write to byte offset 0xC0 + 4*k clears each bit of mailbox k whose write data bit is one. Every other bit of the word is kept.
- R4: A read at offset 0xC0 + 4*k returns mailbox k in the same cycle as the read strobe.
- R5: Read data is zero for a read in the set window (0x80 to 0xBF). It is also zero in any cycle where the read strobe is low.
- R6: Pending flag k is high exactly when mailbox k is nonzero. It shows the result of a write from the cycle after that write's edge.
- R7: A write at an offset below 0x80 changes no mailbox, and a read there returns zero.
- R8: Mailbox j of core c has index k = 4*c + j, and pending bit k belongs to that mailbox.
- R9: A write changes only the mailbox it addresses. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational |
| mbox_pend | output | 16 | Per-mailbox nonzero flags, bit k for mailbox k |

## Verification
The mailbox state can be seen at the ports in two ways: through the pending flags in the cycle after any write, and through clear-window reads in the same cycle. Some faults can change a word without changing whether it is zero. Examples are a wrong index decode, a lost OR, or a clear that inverts the wrong bits. These show on the next read of the affected mailbox, so the bench reads words back often and compares them with its model. A fault in the window decode shows as nonzero data on a set-window read or an outside read, or as a mailbox that changes without being addressed.

// File: rtl/mbox_bank.sv
module mbox_bank #(
  parameter int NUM_CORES = 4,
  parameter int PER_CORE  = 4,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int SET_BASE  = 'h80
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [ADDR_W-1:0]                bus_addr,
  input  logic                             bus_wr,
  input  logic [DATA_W-1:0]                bus_wdata,
  input  logic                             bus_rd,
  output logic [DATA_W-1:0]                bus_rdata,
  output logic [NUM_CORES*PER_CORE-1:0]    mbox_pend
);
  localparam int NUM_MB   = NUM_CORES * PER_CORE;
  localparam int IDX_W    = $clog2(NUM_MB);
  localparam int WIN      = 4 * NUM_MB;
  localparam int CLR_BASE = SET_BASE + WIN;

  logic [DATA_W-1:0] mb [NUM_MB];

  logic              set_hit, clr_hit;
  logic [ADDR_W-1:0] set_off, clr_off;
  logic [IDX_W-1:0]  set_idx, clr_idx;

  assign set_hit = (int'(bus_addr) >= SET_BASE) && (int'(bus_addr) < CLR_BASE);
  assign clr_hit = (int'(bus_addr) >= CLR_BASE) && (int'(bus_addr) < CLR_BASE + WIN);
  assign set_off = bus_addr - ADDR_W'(SET_BASE);
  assign clr_off = bus_addr - ADDR_W'(CLR_BASE);
  assign set_idx = set_off[IDX_W+1:2];
  assign clr_idx = clr_off[IDX_W+1:2];

  assign bus_rdata = (bus_rd && clr_hit) ? mb[clr_idx] : '0;

  for (genvar k = 0; k < NUM_MB; k++) begin : g_mb
    always_ff @(posedge clk) begin
      if (!rst_n)
        mb[k] <= '0;
      else if (bus_wr && set_hit && set_idx == IDX_W'(k))
        mb[k] <= mb[k] | bus_wdata;
      else if (bus_wr && clr_hit && clr_idx == IDX_W'(k))
        mb[k] <= mb[k] & ~bus_wdata;
    end

    assign mbox_pend[k] = |mb[k];

    a_r2_set_or: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && set_hit && set_idx == IDX_W'(k)) |=> ((mb[k] & $past(bus_wdata)) == $past(bus_wdata)));

    a_r3_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && clr_hit && clr_idx == IDX_W'(k)) |=> ((mb[k] & $past(bus_wdata)) == '0));

    a_r9_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && ((set_hit && set_idx == IDX_W'(k)) || (clr_hit && clr_idx == IDX_W'(k))))
      |=> $stable(mb[k]));

    a_r6_pend_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && set_hit && set_idx == IDX_W'(k) && bus_wdata != '0) |=> mbox_pend[k]);
  end

  a_r5_set_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || !clr_hit) |-> (bus_rdata == '0));

  a_r7_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_hit && !clr_hit) |=> $stable(mbox_pend));
endmodule

// File: tb/mbox_bank_tb.sv
module mbox_bank_tb;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  bus_addr = 0;
  logic        bus_wr = 0;
  logic [31:0] bus_wdata = 0;
  logic        bus_rd = 0;
  logic [31:0] bus_rdata;
  logic [15:0] mbox_pend;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] model [16];

  always #(CLK_P/2) clk = ~clk;

  mbox_bank u_dut (.clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rd, .bus_rdata, .mbox_pend);

  function automatic logic [31:0] exp_read(logic [7:0] a);
    if (a >= 8'hC0) return model[a[5:2]];
    return 32'h0;
  endfunction

  function automatic logic [15:0] exp_pend();
    logic [15:0] p;
    for (int k = 0; k < 16; k++) p[k] = (model[k] != 0);
    return p;
  endfunction

  function automatic string tag_of(logic [7:0] a);
    if (a >= 8'hC0) return "R4";
    if (a >= 8'h80) return "R5";
    return "R7";
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic op(bit wr, bit rd, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    #1;
    if (rd) check(bus_rdata == exp_read(a), tag_of(a), bus_rdata, exp_read(a));
    else    check(bus_rdata == 0, "R5", bus_rdata, 0);
    @(posedge clk);
    if (wr && a >= 8'hC0)      model[a[5:2]] &= ~d;
    else if (wr && a >= 8'h80) model[a[5:2]] |= d;
    #1;
    check(mbox_pend == exp_pend(), "R6", {16'h0, mbox_pend}, {16'h0, exp_pend()});
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < 16; k++) model[k] = 0;
    // R1: reset state, with a write attempted during reset
    bus_wr = 1; bus_addr = 8'h80; bus_wdata = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #1;
    check(mbox_pend == 0, "R1", {16'h0, mbox_pend}, 0);
    @(negedge clk); bus_wr = 0; rst_n = 1;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); bus_rd = 1; bus_addr = 8'hC0 + 8'(4*k); #1;
      check(bus_rdata == 0, "R1", bus_rdata, 0);
    end
    // R8: core 2 slot 1 -> index 9
    op(1, 0, 8'h80 + 8'(4*(4*2+1)), 32'h0000_0010);
    check(mbox_pend == 16'h0200, "R8", {16'h0, mbox_pend}, 32'h200);
    // R2: OR accumulates
    op(1, 0, 8'hA4, 32'h0000_0100);
    op(0, 1, 8'hE4, 0);
    check(model[9] == 32'h0000_0110, "R2", model[9], 32'h110);
    // R3: partial clear
    op(1, 0, 8'hE4, 32'h0000_0010);
    op(0, 1, 8'hE4, 0);
    // R9: neighbours untouched, low address bits ignored
    op(1, 0, 8'h8F, 32'hA5A5_0000);
    op(0, 1, 8'hCC, 0);
    op(0, 1, 8'hD0, 0);
    check(bus_rdata == 0, "R9", bus_rdata, 0);
    // R5: set-window read of a nonzero mailbox
    op(0, 1, 8'h8C, 0);
    // R7: outside writes and reads
    op(1, 0, 8'h04, 32'hFFFF_FFFF);
    op(0, 1, 8'h7C, 0);
    op(1, 0, 8'hE4, 32'hFFFF_FFFF);
    op(1, 0, 8'hCC, 32'hFFFF_FFFF);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int sel = $urandom_range(0, 9);
      logic [7:0] a;
      if (sel < 4)      a = 8'h80 + 8'(4 * $urandom_range(0, 15));
      else if (sel < 8) a = 8'hC0 + 8'(4 * $urandom_range(0, 15));
      else              a = 8'($urandom_range(0, 127));
      op($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, a,
         ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom());
    end
    for (int k = 0; k < 16; k++) op(0, 1, 8'hC0 + 8'(4*k), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule